// File: doc/BRIEF.md
# Flow Admission Policer

This block sits at the ingress of a switch port and decides, one flow at a time, whether each arriving packet may enter. It keeps a credit counter. Every admitted packet uses one credit, and a packet that finds no credit is turned away. The credit limit `W` and the refill interval, a number of clock cycles, come from inputs. This lets a flow send a burst of up to `W` packets at once. With a plain one-packet-per-interval scheme, every packet after the first would have to wait.

Two refill disciplines are selectable. In bucket mode, a free-running interval counter adds one credit per interval, and the credit never rises above `W`. In window mode, credit comes back only after traffic leaves. Each transmit-complete strobe books a refill that matures `W` intervals later. Pending refills wait in a small queue of expiry times. When that queue is full, the block raises a stall so that upstream holds further completions.

One instance polices one flow. The decision for an arrival appears as a one-cycle pulse on the clock edge after the arrival is sampled.

Top module: `flow_policer`

## Requirements
- R1: While reset is asserted, `admit_o`, `reject_o` and `tx_stall_o` are 0. After release, the credit starts at `burst_i`, so the first `burst_i` arrivals with no refill in between are admitted.
- R2: An arrival sampled at a clock edge produces exactly one of `admit_o` or `reject_o`, as a one-cycle pulse in the following cycle. With no arrival, both stay 0.
- R3: An arrival is admitted only when the credit is nonzero, and each admission lowers the credit by one. An arrival that finds zero credit is rejected and leaves the credit unchanged.
- R4: In bucket mode (`mode_i`=0), one credit is added at each clock edge numbered k·P after reset release (k = 1, 2, …). Here P is `period_i`, and a value of 0 acts as 1.
- R5: The credit never rises above `burst_i`. Refills that arrive while the credit is full are lost.
- R6: When a refill and an arrival land on the same clock edge, the refill is applied first. An arrival that meets zero credit together with a refill is therefore admitted.
- R7: In window mode (`mode_i`=1), a transmit-complete strobe sampled at edge e returns one credit at edge e + `burst_i`·P. The interval counter adds no credit in this mode.
- R8: In window mode, `tx_stall_o` is 1 while `DEPTH` refills are pending. A transmit-complete strobe sampled while the stall is high is dropped and never returns credit.
- R9: In bucket mode, transmit-complete strobes are ignored: `tx_stall_o` stays 0 and no credit is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| mode_i | input | 1 | 0 = interval bucket refill, 1 = departure-driven window refill |
| period_i | input | PER_W | Clock cycles per refill interval (0 treated as 1) |
| burst_i | input | CNT_W | Credit ceiling and initial credit W |
| arrive_i | input | 1 | Packet arrival strobe |
| tx_done_i | input | 1 | Transmit-complete strobe for a packet of this flow |
| admit_o | output | 1 | Pulse: the arrival of the previous cycle is admitted |
| reject_o | output | 1 | Pulse: the arrival of the previous cycle is refused |
| tx_stall_o | output | 1 | Refill queue full; hold the transmit-complete strobe |

## Verification
The bench aims arrivals at the exact edge where a bucket refill lands, and at the exact edge one cycle before and on the cycle a window refill matures. A design that evaluated admission before adding the credit, or that was off by one in either timer, would reject where an admit is due, or admit one cycle early. It also idles long enough for many intervals to pass before sending a burst. A counter with no ceiling would then admit more than `W` packets. Finally, it over-fills the refill queue in window mode and sends completions in bucket mode. A design that queued past its depth or reacted to the wrong mode would hand back extra credit, and this shows up as an extra admit.

// File: rtl/policer_pkg.sv
package policer_pkg;

  typedef enum logic {
    POL_BUCKET = 1'b0,
    POL_WINDOW = 1'b1
  } pol_mode_e;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/policer_tick_gen.sv
module policer_tick_gen #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);

  logic [PER_W-1:0] phase_q;
  logic [PER_W-1:0] phase_d;
  logic [PER_W-1:0] last_phase;

  always_comb begin
    last_phase = (period_i == '0) ? '0 : period_i - PER_W'(1);
    tick_o     = (phase_q >= last_phase);
    phase_d    = tick_o ? '0 : phase_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/policer_refill_q.sv
module policer_refill_q #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TS_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [TS_W-1:0] delay_i,
  output logic            expire_o,
  output logic            full_o
);

  localparam int unsigned PTR_W = policer_pkg::ptr_bits(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [TS_W-1:0]  slot_q [DEPTH];
  logic [TS_W-1:0]  now_q;
  logic [TS_W-1:0]  now_d;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] fill_q, fill_d;
  logic [TS_W-1:0]  head_ts;
  logic [TS_W-1:0]  age;
  logic             empty;
  logic             do_push;
  logic             do_pop;

  always_comb begin
    empty    = (fill_q == '0);
    full_o   = (fill_q == CNT_W'(DEPTH));
    head_ts  = slot_q[rd_q];
    age      = now_q - head_ts;
    expire_o = !empty && !age[TS_W-1];
    do_push  = push_i && !full_o;
    do_pop   = expire_o;
    now_d    = now_q + TS_W'(1);
    wr_d     = wr_q;
    rd_d     = rd_q;
    fill_d   = fill_q;
    if (do_push) begin
      wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + PTR_W'(1);
    end
    if (do_pop) begin
      rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + PTR_W'(1);
    end
    case ({do_push, do_pop})
      2'b10:   fill_d = fill_q + CNT_W'(1);
      2'b01:   fill_d = fill_q - CNT_W'(1);
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      now_q  <= now_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[g] <= now_q + delay_i;
      end
    end
  end

endmodule

// File: rtl/policer_credit.sv
module policer_credit #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] burst_i,
  input  logic             inc_i,
  input  logic             arrive_i,
  output logic             admit_o,
  output logic             reject_o,
  output logic [CNT_W-1:0] credit_o,
  output logic             primed_o
);

  logic [CNT_W-1:0] credit_q, credit_d;
  logic             primed_q;
  logic             admit_q, admit_d;
  logic             reject_q, reject_d;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] grown;
  logic             take;

  always_comb begin
    base     = primed_q ? credit_q : burst_i;
    grown    = (inc_i && (base < burst_i)) ? base + CNT_W'(1) : base;
    take     = arrive_i && (grown != '0);
    credit_d = take ? grown - CNT_W'(1) : grown;
    admit_d  = take;
    reject_d = arrive_i && !take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
      primed_q <= 1'b0;
      admit_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      credit_q <= credit_d;
      primed_q <= 1'b1;
      admit_q  <= admit_d;
      reject_q <= reject_d;
    end
  end

  assign admit_o  = admit_q;
  assign reject_o = reject_q;
  assign credit_o = credit_q;
  assign primed_o = primed_q;

endmodule

// File: rtl/flow_policer.sv
module flow_policer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PER_W = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] burst_i,
  input  logic             arrive_i,
  input  logic             tx_done_i,
  output logic             admit_o,
  output logic             reject_o,
  output logic             tx_stall_o
);

  import policer_pkg::*;

  pol_mode_e        mode;
  logic             tick;
  logic             expire;
  logic             q_full;
  logic             push;
  logic             inc_any;
  logic [PER_W-1:0] period_eff;
  logic [TS_W-1:0]  delay;
  logic [CNT_W-1:0] credit_w;
  logic             primed_w;

  always_comb begin
    mode       = pol_mode_e'(mode_i);
    period_eff = (period_i == '0) ? PER_W'(1) : period_i;
    delay      = TS_W'(burst_i) * TS_W'(period_eff);
    push       = (mode == POL_WINDOW) && tx_done_i && !q_full;
    inc_any    = (mode == POL_BUCKET) ? tick : expire;
    tx_stall_o = (mode == POL_WINDOW) && q_full;
  end

  policer_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .tick_o   (tick)
  );

  policer_refill_q #(.DEPTH(DEPTH), .TS_W(TS_W)) u_refill (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (push),
    .delay_i  (delay),
    .expire_o (expire),
    .full_o   (q_full)
  );

  policer_credit #(.CNT_W(CNT_W)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .burst_i  (burst_i),
    .inc_i    (inc_any),
    .arrive_i (arrive_i),
    .admit_o  (admit_o),
    .reject_o (reject_o),
    .credit_o (credit_w),
    .primed_o (primed_w)
  );

endmodule

// File: rtl/flow_policer_chk.sv
module flow_policer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arrive_i,
  input logic             admit_o,
  input logic             reject_o,
  input logic [CNT_W-1:0] burst_i,
  input logic [CNT_W-1:0] credit,
  input logic             primed,
  input logic             inc_any
);

  // R2
  one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(admit_o && reject_o));

  // R2
  decision_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arrive_i |=> (admit_o || reject_o));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arrive_i |=> (!admit_o && !reject_o));

  // R3
  empty_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && credit == '0 && !inc_any && arrive_i) |=> reject_o);

  // R5
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $stable(burst_i)) |-> (credit <= burst_i));

endmodule

bind flow_policer flow_policer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arrive_i (arrive_i),
  .admit_o  (admit_o),
  .reject_o (reject_o),
  .burst_i  (burst_i),
  .credit   (credit_w),
  .primed   (primed_w),
  .inc_any  (inc_any)
);

// File: tb/flow_policer_test.sv
`timescale 1ns/1ps
module flow_policer_test;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned PER_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode;
  logic [PER_W-1:0] period;
  logic [CNT_W-1:0] burst;
  logic             arrive;
  logic             txd;
  logic             admit, reject, stall;
  int               checks = 0;
  int               errors = 0;
  int               ecount;
  bit               done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  flow_policer uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .period_i(period), .burst_i(burst),
    .arrive_i(arrive), .tx_done_i(txd),
    .admit_o(admit), .reject_o(reject), .tx_stall_o(stall)
  );

  // Each entry: {arrive, expected admit}; bucket mode, W=3, long interval
  localparam logic [1:0] BURST_VEC [8] = '{
    2'b11, 2'b11, 2'b00, 2'b11, 2'b10, 2'b00, 2'b10, 2'b10
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at edge %0d", tag, act, exp, ecount);
    end
  endtask

  task automatic step(input logic a, input logic t);
    arrive = a; txd = t;
    @(posedge clk);
    @(negedge clk);
    arrive = 1'b0; txd = 1'b0;
  endtask

  task automatic idle_until(input int edge_n);
    while (ecount < edge_n) step(1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic m, input int p, input int w);
    @(negedge clk);
    rst_n = 1'b0; arrive = 1'b0; txd = 1'b0;
    mode = m; period = PER_W'(p); burst = CNT_W'(w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 admit in reset", admit, 1'b0);
    chk("R1 reject in reset", reject, 1'b0);
    chk("R1 stall in reset", stall, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic decide(input string tag, input logic exp_admit);
    step(1'b1, 1'b0);
    chk({tag, " admit"}, admit, exp_admit);
    chk({tag, " reject"}, reject, !exp_admit);
  endtask

  initial begin
    rst_n = 1'b0; arrive = 1'b0; txd = 1'b0;
    mode = 1'b0; period = '0; burst = '0;

    // R1 R2 R3: vector walk through an initial burst
    do_reset(1'b0, 1000, 3);
    for (int i = 0; i < 8; i++) begin
      step(BURST_VEC[i][1], 1'b0);
      chk("R3 vector admit", admit, BURST_VEC[i][0]);
      chk("R2 vector reject", reject, BURST_VEC[i][1] & ~BURST_VEC[i][0]);
    end
    // R6: arrival on the refill edge at zero credit
    idle_until(999);
    decide("R6 same-edge refill", 1'b1);
    decide("R4 credit used", 1'b0);
    // R4: next interval
    idle_until(2000);
    decide("R4 second interval", 1'b1);
    decide("R4 second interval empty", 1'b0);

    // R5: long idle, burst limited to W
    do_reset(1'b0, 5, 3);
    idle_until(100);
    decide("R5 cap 1", 1'b1);
    decide("R5 cap 2", 1'b1);
    decide("R5 cap 3", 1'b1);
    decide("R5 cap exceeded", 1'b0);

    // R9: completions ignored in bucket mode
    do_reset(1'b0, 1000, 3);
    decide("R9 drain", 1'b1);
    decide("R9 drain", 1'b1);
    decide("R9 drain", 1'b1);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      chk("R9 no stall", stall, 1'b0);
    end
    idle_until(40);
    decide("R9 no credit back", 1'b0);

    // R7: window refill timing, W=2 P=4 -> 8 cycles
    do_reset(1'b1, 4, 2);
    decide("R7 first", 1'b1);
    arrive = 1'b1; txd = 1'b1;
    @(posedge clk); @(negedge clk);
    arrive = 1'b0; txd = 1'b0;
    chk("R7 second admit", admit, 1'b1);
    idle_until(8);
    decide("R7 one cycle early", 1'b0);
    decide("R7 matured refill", 1'b1);
    idle_until(40);
    decide("R7 ticks ignored", 1'b0);

    // R8: refill queue full
    do_reset(1'b1, 50, 6);
    for (int i = 0; i < 6; i++) decide("R8 drain", 1'b1);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b1);
      chk("R8 stall level", stall, (i >= 3) ? 1'b1 : 1'b0);
    end
    idle_until(320);
    chk("R8 stall cleared", stall, 1'b0);
    for (int i = 0; i < 4; i++) decide("R8 returned credit", 1'b1);
    decide("R8 dropped strobe", 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule